// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the transfer state of a single DMA channel. It holds a 16-bit current address counter, an 8-bit page register and a 16-bit current transfer count, each current counter backed by a base copy. From these it forms a 24-bit physical byte address. The bus arbiter pulses a transfer strobe once per completed bus transfer. On each strobe the address steps forward by one, and the count steps back by one in the same clock.

The channel runs in one of two modes. In byte mode the counter addresses bytes inside a 64K page. In word mode the counter addresses 16-bit words inside a 128K page: the counter is shifted up by one bit, the page supplies only its upper seven bits, and the lowest byte address bit is zero. In both modes the counter wraps inside the page and never carries into the page register. The programmed count is the number of transfers minus one. When the last transfer happens, a terminal-count pulse is raised. The channel then either stops or, with auto-initialise selected, reloads its current registers from the base copies.

Programming reaches the block through plain load strobes with data. The strobe, load and status pins are control signals with no handshake, so no valid/ready back-pressure applies at this edge.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, current address, current count and page are 0x0000, 0x0000 and 0x00, `chan_active` is 0, `term_cnt` is 0, and auto-initialise is off.
- R2: With `word_mode`=0, `phys_addr[23:16]` equals the page and `phys_addr[15:0]` equals the current address.
- R3: With `word_mode`=1, `phys_addr[23:17]` equals page bits 7:1, `phys_addr[16:1]` equals the current address, and `phys_addr[0]` is 0. Page bit 0 has no effect on the output.
- R4: On a strobe, an address of 0xFFFF wraps to 0x0000 and the page register is unchanged. The physical address therefore stays inside the same 64K (byte mode) or 128K (word mode) region.
- R5: A strobe to an active channel adds one to the current address and subtracts one from the current count in the same clock.
- R6: `term_cnt` is high, combinationally and for that cycle only, when a strobe reaches an active channel whose count is 0x0000. The count then becomes 0xFFFF, so the remaining-count value (count + 1, 16-bit wrap) reads zero. Without auto-initialise, `chan_active` drops to 0.
- R7: A mode write with `mode_din` bit 4 set selects auto-initialise. On terminal count the current address and current count are then reloaded from their base copies, and the channel stays active.
- R8: An address or count load writes both the base copy and the current copy. A count load also makes the channel active.
- R9: A strobe to an inactive channel changes no state and raises no `term_cnt`.
- R10: A loaded count of N gives exactly N+1 transfers. 0x0000 gives 1 transfer and 0xFFFF gives 65536 transfers.
- R11: A load in the same cycle as a strobe takes priority for the register it loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_mode | input | 1 | 1 selects a 16-bit word channel, 0 a byte channel |
| mode_we | input | 1 | Mode write strobe |
| mode_din | input | 8 | Mode byte; bit 4 selects auto-initialise |
| page_we | input | 1 | Page register load strobe |
| page_din | input | 8 | Page value |
| addr_we | input | 1 | Base/current address load strobe |
| addr_din | input | 16 | Address value |
| cnt_we | input | 1 | Base/current count load strobe; arms the channel |
| cnt_din | input | 16 | Transfer count minus one |
| xfer_stb | input | 1 | One pulse per completed transfer |
| phys_addr | output | 24 | Physical byte address |
| cur_addr | output | 16 | Current address counter |
| cur_cnt | output | 16 | Current count |
| term_cnt | output | 1 | Terminal count pulse |
| chan_active | output | 1 | Channel is still requesting service |

## Verification
Address mapping is tried with page and address pairs in both modes, at all-zero and all-one corners. One pair differs only in page bit 0, which separates a correct word mapping from one that leaks that bit. Wrap tests start at 0xFFFF in each mode to show whether a carry reaches the page. Count runs of one, two, three and 65536 transfers separate a count-minus-one encoding from an off-by-one. Paired runs with and without auto-initialise show whether the reload, rather than a stop, follows terminal count.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int unsigned CTR_W  = 16;
  localparam int unsigned PAGE_W = 8;
  localparam int unsigned PHYS_W = CTR_W + PAGE_W;
  localparam int unsigned AUTOINIT_BIT = 4;

  typedef enum logic {
    STEP_DOWN = 1'b0,
    STEP_UP   = 1'b1
  } step_dir_e;
endpackage

// File: rtl/dce_reg_ctr.sv
module dce_reg_ctr
  import dma_chan_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter step_dir_e   DIR = STEP_UP
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] din,
  input  logic         step,
  input  logic         reload,
  output logic [W-1:0] cur
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] base_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] stepped;

  generate
    if (DIR == STEP_UP) begin : g_up
      assign stepped = cur_q + ONE;
    end else begin : g_down
      assign stepped = cur_q - ONE;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else if (ld) begin
      base_q <= din;
      cur_q  <= din;
    end else if (reload) begin
      cur_q  <= base_q;
    end else if (step) begin
      cur_q  <= stepped;
    end
  end

  assign cur = cur_q;

  generate
    if (DIR == STEP_UP) begin : g_chk_up
      assert_step_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && !reload) |=> (cur_q == $past(cur_q) + ONE));
    end else begin : g_chk_down
      assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld && !reload) |=> (cur_q == $past(cur_q) - ONE));
    end
  endgenerate

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (cur_q == $past(din)));

  assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !ld) |=> (cur_q == $past(base_q)));
endmodule

// File: rtl/dce_addr_map.sv
module dce_addr_map
  import dma_chan_pkg::*;
#(
  parameter int unsigned CW = CTR_W,
  parameter int unsigned PW = PAGE_W,
  localparam int unsigned OW = CW + PW
) (
  input  logic          word_mode,
  input  logic [PW-1:0] page,
  input  logic [CW-1:0] ctr,
  output logic [OW-1:0] phys
);
  logic [OW-1:0] byte_phys;
  logic [OW-1:0] word_phys;

  assign byte_phys = {page, ctr};
  assign word_phys = {page[PW-1:1], ctr, 1'b0};

  always_comb begin
    phys = word_mode ? word_phys : byte_phys;
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               word_mode,
  input  logic               mode_we,
  input  logic [7:0]         mode_din,
  input  logic               page_we,
  input  logic [PAGE_W-1:0]  page_din,
  input  logic               addr_we,
  input  logic [CTR_W-1:0]   addr_din,
  input  logic               cnt_we,
  input  logic [CTR_W-1:0]   cnt_din,
  input  logic               xfer_stb,
  output logic [PHYS_W-1:0]  phys_addr,
  output logic [CTR_W-1:0]   cur_addr,
  output logic [CTR_W-1:0]   cur_cnt,
  output logic               term_cnt,
  output logic               chan_active
);
  logic [PAGE_W-1:0] page_q;
  logic              autoinit_q;
  logic              active_q;
  logic              adv;
  logic              last_xfer;
  logic              reload;

  assign adv       = xfer_stb && active_q;
  assign last_xfer = adv && (cur_cnt == '0);
  assign reload    = last_xfer && autoinit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q     <= '0;
      autoinit_q <= 1'b0;
      active_q   <= 1'b0;
    end else begin
      if (page_we) page_q <= page_din;
      if (mode_we) autoinit_q <= mode_din[AUTOINIT_BIT];
      if (cnt_we) begin
        active_q <= 1'b1;
      end else if (last_xfer && !autoinit_q) begin
        active_q <= 1'b0;
      end
    end
  end

  dce_reg_ctr #(.W(CTR_W), .DIR(STEP_UP)) u_addr (
    .clk(clk), .rst_n(rst_n), .ld(addr_we), .din(addr_din),
    .step(adv), .reload(reload), .cur(cur_addr)
  );

  dce_reg_ctr #(.W(CTR_W), .DIR(STEP_DOWN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld(cnt_we), .din(cnt_din),
    .step(adv), .reload(reload), .cur(cur_cnt)
  );

  dce_addr_map #(.CW(CTR_W), .PW(PAGE_W)) u_map (
    .word_mode(word_mode), .page(page_q), .ctr(cur_addr), .phys(phys_addr)
  );

  assign term_cnt    = last_xfer;
  assign chan_active = active_q;

  assert_tc_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    term_cnt |-> (cur_cnt == '0));

  assert_tc_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (term_cnt && !autoinit_q && !cnt_we) |=> !chan_active);

  assert_auto_stay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (term_cnt && autoinit_q) |=> chan_active);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_active |-> !term_cnt);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_active && !addr_we) |=> $stable(cur_addr));

  assert_page_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !page_we |=> $stable(page_q));

  assert_word_lsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_mode |-> (phys_addr[0] == 1'b0));
endmodule

// File: tb/sim_dma_chan_engine.sv
module sim_dma_chan_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_mode = 1'b0;
  logic        mode_we = 1'b0;
  logic [7:0]  mode_din = '0;
  logic        page_we = 1'b0;
  logic [7:0]  page_din = '0;
  logic        addr_we = 1'b0;
  logic [15:0] addr_din = '0;
  logic        cnt_we = 1'b0;
  logic [15:0] cnt_din = '0;
  logic        xfer_stb = 1'b0;
  logic [23:0] phys_addr;
  logic [15:0] cur_addr;
  logic [15:0] cur_cnt;
  logic        term_cnt;
  logic        chan_active;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_chan_engine u0 (
    .clk(clk), .rst_n(rst_n), .word_mode(word_mode),
    .mode_we(mode_we), .mode_din(mode_din),
    .page_we(page_we), .page_din(page_din),
    .addr_we(addr_we), .addr_din(addr_din),
    .cnt_we(cnt_we), .cnt_din(cnt_din),
    .xfer_stb(xfer_stb), .phys_addr(phys_addr), .cur_addr(cur_addr),
    .cur_cnt(cur_cnt), .term_cnt(term_cnt), .chan_active(chan_active)
  );

  // {word_mode, page, address, expected physical address}
  localparam int NV = 8;
  localparam logic [48:0] VEC [NV] = '{
    {1'b0, 8'h12, 16'h3456, 24'h123456},
    {1'b0, 8'hFF, 16'hFFFF, 24'hFFFFFF},
    {1'b0, 8'h01, 16'h0000, 24'h010000},
    {1'b0, 8'h00, 16'h0001, 24'h000001},
    {1'b1, 8'h12, 16'h3456, 24'h1268AC},
    {1'b1, 8'h13, 16'h3456, 24'h1268AC},
    {1'b1, 8'hFF, 16'hFFFF, 24'hFFFFFE},
    {1'b1, 8'h01, 16'h8000, 24'h010000}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    mode_we = 0; page_we = 0; addr_we = 0; cnt_we = 0; xfer_stb = 0;
  endtask

  task automatic load(input logic [7:0] pg, input logic [15:0] ad, input logic [15:0] ct);
    page_we = 1; page_din = pg; addr_we = 1; addr_din = ad; cnt_we = 1; cnt_din = ct;
    tick();
  endtask

  task automatic set_mode(input logic [7:0] m);
    mode_we = 1; mode_din = m;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 addr", {16'h0, cur_addr}, 32'h0);
    chk("R1 cnt", {16'h0, cur_cnt}, 32'h0);
    chk("R1 phys", {8'h0, phys_addr}, 32'h0);
    chk("R1 active", {31'h0, chan_active}, 32'h0);
    chk("R1 tc", {31'h0, term_cnt}, 32'h0);

    // R2/R3 mapping table
    for (int i = 0; i < NV; i++) begin
      word_mode = VEC[i][48];
      load(VEC[i][47:40], VEC[i][39:24], 16'h0005);
      chk(VEC[i][48] ? "R3 word map" : "R2 byte map", {8'h0, phys_addr}, {8'h0, VEC[i][23:0]});
    end

    // R4 wrap in byte mode
    word_mode = 0;
    load(8'h12, 16'hFFFF, 16'h0005);
    xfer_stb = 1; tick();
    chk("R4 byte wrap addr", {16'h0, cur_addr}, 32'h0);
    chk("R4 byte wrap phys", {8'h0, phys_addr}, 32'h120000);
    // R4 wrap in word mode
    word_mode = 1;
    load(8'h13, 16'hFFFF, 16'h0005);
    chk("R4 word pre phys", {8'h0, phys_addr}, 32'h13FFFE);
    xfer_stb = 1; tick();
    chk("R4 word wrap phys", {8'h0, phys_addr}, 32'h120000);
    word_mode = 0;

    // R5 step, R8 load both copies
    load(8'h00, 16'h1000, 16'h0010);
    chk("R8 cur addr", {16'h0, cur_addr}, 32'h1000);
    chk("R8 cur cnt", {16'h0, cur_cnt}, 32'h0010);
    chk("R8 active", {31'h0, chan_active}, 32'h1);
    xfer_stb = 1; tick();
    chk("R5 addr", {16'h0, cur_addr}, 32'h1001);
    chk("R5 cnt", {16'h0, cur_cnt}, 32'h000F);

    // R11 load wins over strobe
    xfer_stb = 1; addr_we = 1; addr_din = 16'h2222; tick();
    chk("R11 addr load", {16'h0, cur_addr}, 32'h2222);
    chk("R11 cnt stepped", {16'h0, cur_cnt}, 32'h000E);
    xfer_stb = 1; cnt_we = 1; cnt_din = 16'h0033; tick();
    chk("R11 cnt load", {16'h0, cur_cnt}, 32'h0033);
    chk("R11 addr stepped", {16'h0, cur_addr}, 32'h2223);

    // R6 terminal count, no auto-init, count 1 => two transfers
    set_mode(8'h00);
    load(8'h00, 16'h5000, 16'h0001);
    xfer_stb = 1; #1;
    chk("R6 no tc first", {31'h0, term_cnt}, 32'h0);
    tick();
    xfer_stb = 1; #1;
    chk("R6 tc on last", {31'h0, term_cnt}, 32'h1);
    tick();
    chk("R6 tc one cycle", {31'h0, term_cnt}, 32'h0);
    chk("R6 cnt ffff", {16'h0, cur_cnt}, 32'hFFFF);
    chk("R6 residue zero", {16'h0, cur_cnt + 16'h1}, 32'h0);
    chk("R6 stopped", {31'h0, chan_active}, 32'h0);
    chk("R6 addr", {16'h0, cur_addr}, 32'h5002);

    // R9 strobe on inactive channel
    xfer_stb = 1; #1;
    chk("R9 no tc", {31'h0, term_cnt}, 32'h0);
    tick();
    chk("R9 addr held", {16'h0, cur_addr}, 32'h5002);
    chk("R9 cnt held", {16'h0, cur_cnt}, 32'hFFFF);

    // R7 auto-initialise, count 2 => three transfers then reload
    set_mode(8'h10);
    load(8'h00, 16'h1230, 16'h0002);
    xfer_stb = 1; tick();
    xfer_stb = 1; tick();
    xfer_stb = 1; #1;
    chk("R7 tc", {31'h0, term_cnt}, 32'h1);
    tick();
    chk("R7 reload addr", {16'h0, cur_addr}, 32'h1230);
    chk("R7 reload cnt", {16'h0, cur_cnt}, 32'h0002);
    chk("R7 still active", {31'h0, chan_active}, 32'h1);

    // R10 count 0 => one transfer
    set_mode(8'h00);
    load(8'h00, 16'h0000, 16'h0000);
    xfer_stb = 1; #1;
    chk("R10 single tc", {31'h0, term_cnt}, 32'h1);
    tick();

    // R10 count ffff => 65536 transfers
    load(8'h00, 16'h0000, 16'hFFFF);
    begin
      int n = 0;
      bit seen = 0;
      while (!seen && n < 70000) begin
        xfer_stb = 1; #1;
        n++;
        if (term_cnt) seen = 1;
        tick();
      end
      chk("R10 65536 transfers", n, 32'd65536);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule